// File: doc/BRIEF.md
# Nibble ALU and Memory Execution Unit

This block carries out one already-decoded instruction of a small 4-bit machine on each clock edge where its execute strobe is high. It owns four 4-bit registers and a data array of 256 four-bit words. Arithmetic and logic operations always read registers 0 and 1 and always write register 2. Transfer operations move a literal into a register, move nibbles between a register and memory, or store a literal straight into memory.

A sequencer outside the block fetches the 16-bit instruction word, presents it with the strobe, and reads any register back through a combinational select port to make a branch decision. The block does not fetch instructions or hold a program counter. Control-flow and reserved opcodes reach the block but leave its state untouched. A carry/borrow flag keeps the outcome of the most recent add or subtract.

Top module: `nibble_exec_unit`

## Requirements
- R1: A synchronous active-high reset clears all four registers and the carry flag to 0 on the next clock edge.
- R2: Opcode 0000 (instr[15:12]) writes (reg0 + reg1) mod 16 into reg2, and sets carry to 1 exactly when the true sum exceeds 15.
- R3: Opcode 0001 writes (reg0 - reg1) mod 16 into reg2, and sets carry to 1 exactly when reg1 is greater than reg0 (a borrow).
- R4: Opcodes 0100, 0101, 0110 and 0111 write into reg2, in that order, NOT reg0, reg0 XOR reg1, reg0 OR reg1 and reg0 AND reg1.
- R5: Opcode 0010 writes the literal in instr[7:4] into the register selected by instr[1:0]. Bits instr[11:8] and instr[3:2] have no effect.
- R6: Opcode 1000 stores the literal in instr[3:0] into memory at the address in instr[11:4].
- R7: Opcode 1001 loads memory[instr[11:4]] into the register selected by instr[1:0]. Opcode 1010 stores the register selected by instr[1:0] into memory[instr[11:4]].
- R8: Opcodes 0011, 1011, 1100, 1101, 1110 and 1111 change no register, no memory word and not the carry flag.
- R9: While the execute strobe is low, no register, memory word or carry flag changes, whatever the instruction word holds.
- R10: The carry flag changes only on an executed add or subtract. rd_data_o shows the register chosen by rd_sel_i combinationally, without waiting for a clock.
- R11: Memory contents are kept across a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset of the registers and carry |
| exec_en_i | input | 1 | Execute strobe; the instruction takes effect on an edge where it is high |
| instr_i | input | 16 | Instruction word: opcode [15:12], A field [11:4], B field [3:0] |
| rd_sel_i | input | 2 | Selects the register shown on rd_data_o |
| rd_data_o | output | 4 | Current value of the selected register |
| carry_o | output | 1 | Carry/borrow of the most recent add or subtract |

## Verification
A wrong register value becomes visible on rd_data_o as soon as rd_sel_i points at that register. This is the same cycle as the edge that stored it, because the read path is combinational. A corrupted memory word is hidden until a later load copies it into a register, so every memory check is followed by a load and a register read. A carry flag that is updated when it should not be shows up on carry_o right after the first logic, transfer or no-effect instruction that follows an add or subtract.

// File: rtl/nx_pkg.sv
package nx_pkg;

    localparam int NX_DW    = 4;
    localparam int NX_AW    = 8;
    localparam int NX_NREG  = 4;
    localparam int NX_RSW   = $clog2(NX_NREG);
    localparam int NX_OPW   = 4;
    localparam int NX_BW    = 4;
    localparam int NX_IW    = NX_OPW + NX_AW + NX_BW;
    localparam int NX_DEPTH = 1 << NX_AW;

    // Destination of every arithmetic and logic result
    localparam logic [NX_RSW-1:0] NX_ALU_DST = 2'd2;

    typedef enum logic [NX_OPW-1:0] {
        OP_ADD  = 4'b0000,
        OP_SUB  = 4'b0001,
        OP_LIT  = 4'b0010,
        OP_NOP  = 4'b0011,
        OP_INV  = 4'b0100,
        OP_XOR  = 4'b0101,
        OP_OR   = 4'b0110,
        OP_AND  = 4'b0111,
        OP_MST  = 4'b1000,
        OP_MLD  = 4'b1001,
        OP_MWR  = 4'b1010,
        OP_RSV0 = 4'b1011,
        OP_JMP  = 4'b1100,
        OP_RSV1 = 4'b1101,
        OP_JEQ  = 4'b1110,
        OP_RSV2 = 4'b1111
    } nx_op_e;

    typedef struct packed {
        nx_op_e            op;
        logic [NX_AW-1:0]  a;
        logic [NX_BW-1:0]  b;
    } nx_instr_t;

    typedef logic [NX_NREG-1:0][NX_DW-1:0] nx_regs_t;

    typedef struct packed {
        logic              we;
        logic [NX_RSW-1:0] sel;
        logic [NX_DW-1:0]  data;
    } nx_rwr_t;

    typedef struct packed {
        logic              we;
        logic [NX_DW-1:0]  data;
    } nx_mwr_t;

    function automatic logic nx_is_arith(input nx_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

    function automatic logic nx_is_logic(input nx_op_e op);
        return op[3:2] == 2'b01;
    endfunction

endpackage

// File: rtl/nx_alu.sv
module nx_alu
    import nx_pkg::*;
#(
    parameter int DW = NX_DW
) (
    input  nx_op_e        op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] res_o,
    output logic          cy_o
);

    logic [DW:0] sum_w;
    logic [DW:0] diff_w;

    assign sum_w  = {1'b0, a_i} + {1'b0, b_i};
    assign diff_w = {1'b0, a_i} - {1'b0, b_i};

    always_comb begin
        res_o = '0;
        cy_o  = 1'b0;
        unique case (op_i)
            OP_ADD: begin res_o = sum_w[DW-1:0];  cy_o = sum_w[DW];  end
            OP_SUB: begin res_o = diff_w[DW-1:0]; cy_o = diff_w[DW]; end
            OP_INV: res_o = ~a_i;
            OP_XOR: res_o = a_i ^ b_i;
            OP_OR:  res_o = a_i | b_i;
            OP_AND: res_o = a_i & b_i;
            default: begin res_o = '0; cy_o = 1'b0; end
        endcase
    end

endmodule

// File: rtl/nx_regfile.sv
module nx_regfile
    import nx_pkg::*;
#(
    parameter int DW   = NX_DW,
    parameter int NREG = NX_NREG,
    localparam int RSW = $clog2(NREG)
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      we_i,
    input  logic [RSW-1:0]            sel_i,
    input  logic [DW-1:0]             data_i,
    output logic [NREG-1:0][DW-1:0]   regs_o
);

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        logic [DW-1:0] q;
        always_ff @(posedge clk_i) begin
            if (rst_i)
                q <= '0;
            else if (we_i && (sel_i == RSW'(gi)))
                q <= data_i;
        end
        assign regs_o[gi] = q;
    end

endmodule

// File: rtl/nx_dmem.sv
module nx_dmem
    import nx_pkg::*;
#(
    parameter int DW = NX_DW,
    parameter int AW = NX_AW,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i)
            mem_q[addr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/nibble_exec_unit.sv
module nibble_exec_unit
    import nx_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              exec_en_i,
    input  logic [NX_IW-1:0]  instr_i,
    input  logic [NX_RSW-1:0] rd_sel_i,
    output logic [NX_DW-1:0]  rd_data_o,
    output logic              carry_o
);

    nx_instr_t        ins_w;
    nx_regs_t         regs_w;
    nx_rwr_t          rwr_w;
    nx_mwr_t          mwr_w;
    logic [NX_DW-1:0] alu_res_w;
    logic             alu_cy_w;
    logic [NX_DW-1:0] mem_rd_w;
    logic             cy_we_w;
    logic             cy_q;
    logic [NX_RSW-1:0] bsel_w;

    assign ins_w  = nx_instr_t'(instr_i);
    assign bsel_w = ins_w.b[NX_RSW-1:0];

    nx_alu #(.DW(NX_DW)) u_alu (
        .op_i  (ins_w.op),
        .a_i   (regs_w[0]),
        .b_i   (regs_w[1]),
        .res_o (alu_res_w),
        .cy_o  (alu_cy_w)
    );

    // Decode: one register write and one memory write at most per instruction
    always_comb begin
        rwr_w   = '0;
        mwr_w   = '0;
        cy_we_w = 1'b0;
        if (nx_is_arith(ins_w.op) || nx_is_logic(ins_w.op)) begin
            rwr_w.we   = 1'b1;
            rwr_w.sel  = NX_ALU_DST;
            rwr_w.data = alu_res_w;
            cy_we_w    = nx_is_arith(ins_w.op);
        end else begin
            unique case (ins_w.op)
                OP_LIT: begin
                    rwr_w.we   = 1'b1;
                    rwr_w.sel  = bsel_w;
                    rwr_w.data = ins_w.a[NX_DW-1:0];
                end
                OP_MLD: begin
                    rwr_w.we   = 1'b1;
                    rwr_w.sel  = bsel_w;
                    rwr_w.data = mem_rd_w;
                end
                OP_MST: begin
                    mwr_w.we   = 1'b1;
                    mwr_w.data = ins_w.b[NX_DW-1:0];
                end
                OP_MWR: begin
                    mwr_w.we   = 1'b1;
                    mwr_w.data = regs_w[bsel_w];
                end
                default: begin
                    rwr_w = '0;
                    mwr_w = '0;
                end
            endcase
        end
    end

    nx_regfile #(.DW(NX_DW), .NREG(NX_NREG)) u_regs (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .we_i   (rwr_w.we && exec_en_i),
        .sel_i  (rwr_w.sel),
        .data_i (rwr_w.data),
        .regs_o (regs_w)
    );

    nx_dmem #(.DW(NX_DW), .AW(NX_AW)) u_mem (
        .clk_i   (clk_i),
        .we_i    (mwr_w.we && exec_en_i),
        .addr_i  (ins_w.a),
        .wdata_i (mwr_w.data),
        .rdata_o (mem_rd_w)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i)
            cy_q <= 1'b0;
        else if (cy_we_w && exec_en_i)
            cy_q <= alu_cy_w;
    end

    assign carry_o   = cy_q;
    assign rd_data_o = regs_w[rd_sel_i];

endmodule

// File: rtl/nx_checker.sv
module nx_checker
    import nx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             exec_en,
    input logic [NX_IW-1:0] instr,
    input nx_regs_t         regs,
    input logic             carry
);

    logic [NX_OPW-1:0] op;
    logic              quiet_op;
    assign op       = instr[NX_IW-1 -: NX_OPW];
    assign quiet_op = (op == 4'b0011) || (op == 4'b1011) || (op[3:2] == 2'b11);

    // R1: reset clears registers and carry
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (regs == '0) && !carry);

    // R2: add result into register 2
    a_r2_add_wrap: assert property (@(posedge clk) disable iff (rst)
        (exec_en && op == 4'b0000) |=>
        regs[2] == NX_DW'($past(regs[0]) + $past(regs[1])));

    // R3: subtract borrow flag
    a_r3_sub_borrow: assert property (@(posedge clk) disable iff (rst)
        (exec_en && op == 4'b0001) |=> carry == ($past(regs[1]) > $past(regs[0])));

    // R5: literal load lands in the selected register
    a_r5_literal: assert property (@(posedge clk) disable iff (rst)
        (exec_en && op == 4'b0010) |=> regs[$past(instr[1:0])] == $past(instr[7:4]));

    // R8: no-effect opcodes hold registers and carry
    a_r8_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        (exec_en && quiet_op) |=> $stable(regs) && $stable(carry));

    // R9: idle strobe holds registers and carry
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !exec_en |=> $stable(regs) && $stable(carry));

    // R10: carry moves only on add or subtract
    a_r10_carry_only_arith: assert property (@(posedge clk) disable iff (rst)
        (exec_en && op[3:1] != 3'b000) |=> $stable(carry));

endmodule

bind nibble_exec_unit nx_checker u_nx_checker (
    .clk     (clk_i),
    .rst     (rst_i),
    .exec_en (exec_en_i),
    .instr   (instr_i),
    .regs    (regs_w),
    .carry   (carry_o)
);

// File: tb/nibble_exec_unit_bench.sv
module nibble_exec_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exec_en = 1'b0;
    logic [15:0] instr = '0;
    logic [1:0]  rd_sel = '0;
    logic [3:0]  rd_data;
    logic        carry;

    always #(CLK_PERIOD/2) clk = ~clk;

    nibble_exec_unit u_nibble_exec_unit (
        .clk_i     (clk),
        .rst_i     (rst),
        .exec_en_i (exec_en),
        .instr_i   (instr),
        .rd_sel_i  (rd_sel),
        .rd_data_o (rd_data),
        .carry_o   (carry)
    );

    typedef struct {
        logic [1:0] sel;
        logic [3:0] val;
        logic       cy;
        string      tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference model
    logic [3:0] m_reg [4];
    logic [3:0] m_mem [256];
    logic       m_cy;

    function automatic logic [15:0] mk(input logic [3:0] op, input logic [7:0] a, input logic [3:0] b);
        return {op, a, b};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) m_reg[i] = 4'h0;
        m_cy = 1'b0;
    endtask

    // Driver: executes one instruction and updates the model
    task automatic run(input logic [3:0] op, input logic [7:0] a, input logic [3:0] b);
        logic [4:0] t;
        @(negedge clk);
        instr   = mk(op, a, b);
        exec_en = 1'b1;
        @(negedge clk);
        exec_en = 1'b0;
        case (op)
            4'h0: begin t = {1'b0, m_reg[0]} + {1'b0, m_reg[1]}; m_reg[2] = t[3:0]; m_cy = (t > 5'd15); end
            4'h1: begin m_reg[2] = m_reg[0] - m_reg[1]; m_cy = (m_reg[1] > m_reg[0]); end
            4'h2: m_reg[b[1:0]] = a[3:0];
            4'h4: m_reg[2] = ~m_reg[0];
            4'h5: m_reg[2] = m_reg[0] ^ m_reg[1];
            4'h6: m_reg[2] = m_reg[0] | m_reg[1];
            4'h7: m_reg[2] = m_reg[0] & m_reg[1];
            4'h8: m_mem[a] = b;
            4'h9: m_reg[b[1:0]] = m_mem[a];
            4'hA: m_mem[a] = m_reg[b[1:0]];
            default: ;
        endcase
    endtask

    task automatic expect_reg(input logic [1:0] sel, input string tag);
        item_t it;
        it.sel = sel; it.val = m_reg[sel]; it.cy = m_cy; it.tag = tag;
        q.push_back(it);
        wait (q.size() == 0);
        #2;
    endtask

    task automatic expect_all(input string tag);
        for (int i = 0; i < 4; i++) expect_reg(2'(i), tag);
    endtask

    // Monitor: selects the register and compares with the expected item
    initial begin
        item_t it;
        forever begin
            wait (q.size() > 0);
            it = q[0];
            rd_sel = it.sel;
            #1;
            checks++;
            if (rd_data !== it.val || carry !== it.cy) begin
                errors++;
                $display("FAIL %s: reg%0d actual=%h carry=%b expected=%h carry=%b",
                         it.tag, it.sel, rd_data, carry, it.val, it.cy);
            end
            void'(q.pop_front());
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        expect_all("R1 reset state");

        // R5: literal loads, ignoring upper A bits and upper B bits
        run(4'h2, 8'hA5, 4'h0);
        run(4'h2, 8'h03, 4'hD);
        run(4'h2, 8'h7F, 4'h3);
        expect_all("R5 literal load");

        // R2: add, no carry then wrap with carry
        run(4'h0, 8'h00, 4'h0);
        expect_reg(2'd2, "R2 add 5+3");
        run(4'h2, 8'h09, 4'h0);
        run(4'h2, 8'h08, 4'h1);
        run(4'h0, 8'h00, 4'h0);
        expect_reg(2'd2, "R2 add wrap 9+8");

        // R3: subtract, no borrow then borrow
        run(4'h1, 8'h00, 4'h0);
        expect_reg(2'd2, "R3 sub 9-8");
        run(4'h2, 8'h03, 4'h0);
        run(4'h2, 8'h05, 4'h1);
        run(4'h1, 8'h00, 4'h0);
        expect_reg(2'd2, "R3 sub borrow 3-5");

        // R4 and R10: logic ops keep carry (set to 1 above)
        run(4'h2, 8'h0C, 4'h0);
        run(4'h2, 8'h0A, 4'h1);
        run(4'h4, 8'h00, 4'h0);
        expect_reg(2'd2, "R4 not / R10 carry held");
        run(4'h5, 8'h00, 4'h0);
        expect_reg(2'd2, "R4 xor");
        run(4'h6, 8'h00, 4'h0);
        expect_reg(2'd2, "R4 or");
        run(4'h7, 8'h00, 4'h0);
        expect_reg(2'd2, "R4 and / R10 carry held");

        // R6/R7: store literals at both address ends, load back
        run(4'h8, 8'h00, 4'h9);
        run(4'h8, 8'hFF, 4'h6);
        run(4'h9, 8'h00, 4'h3);
        expect_reg(2'd3, "R6 store/load addr 00");
        run(4'h9, 8'hFF, 4'h0);
        expect_reg(2'd0, "R6 store/load addr FF");
        run(4'hA, 8'h42, 4'h3);
        run(4'h9, 8'h42, 4'h1);
        expect_reg(2'd1, "R7 reg write then load");

        // R8: no-effect opcodes aimed at 0xFF and reg 3
        for (int k = 0; k < 6; k++) begin
            logic [3:0] opc;
            opc = (k == 0) ? 4'h3 : (k == 1) ? 4'hB : 4'(4'hC + (k - 2));
            run(opc, 8'hFF, 4'hF);
        end
        expect_all("R8 quiet opcodes regs/carry");
        run(4'h9, 8'hFF, 4'h2);
        expect_reg(2'd2, "R8 quiet opcodes memory");

        // R9: strobe low, store and literal presented for several cycles
        @(negedge clk);
        instr = mk(4'h8, 8'hFF, 4'h1);
        repeat (3) @(negedge clk);
        instr = mk(4'h2, 8'h0E, 4'h2);
        repeat (3) @(negedge clk);
        instr = mk(4'h0, 8'h00, 4'h0);
        repeat (3) @(negedge clk);
        expect_all("R9 idle regs/carry");
        run(4'h9, 8'hFF, 4'h3);
        expect_reg(2'd3, "R9 idle memory");

        // R10: combinational read follows select with no clock
        expect_reg(2'd0, "R10 read select");
        expect_reg(2'd1, "R10 read select");

        // R1/R11: reset clears registers but keeps memory
        do_reset();
        expect_all("R1 reset after use");
        run(4'h9, 8'h00, 4'h1);
        expect_reg(2'd1, "R11 memory kept over reset");
        run(4'h9, 8'h42, 4'h2);
        expect_reg(2'd2, "R11 memory kept over reset");

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule